// File: doc/BRIEF.md
# Dual-Lane Accumulator Interpolator

This block holds two 32-bit accumulators and three base registers behind a word-addressed register port. Each lane reads an accumulator, its own or the other lane's. It shifts that value right, keeps only a programmable inclusive bit window and can sign-extend the result from the top bit of the window. It then adds the lane's base. A third result, FULL, adds the third base to both lanes' windowed values.

Software reads any result through the same port in one of two ways. A peek read has no side effects. A pop read returns the same value and, on the clock edge that ends the read, loads both accumulators with new values. Each accumulator takes either its own lane's result or the other lane's result. Per-lane control also offers a raw mode, which adds the whole selected accumulator to the base, and two forced bits that are ORed into the upper address bits of the value seen on the bus.

Top module: `interp_lanes`

## Requirements
- R1: After reset every register reads zero. `rdata` is zero in every cycle where `rd_en` is low.
- R2: Word addresses 0 and 1 are ACC0 and ACC1. Addresses 2, 3 and 4 are BASE0, BASE1 and BASE2. Addresses 5 and 6 are CTRL0 and CTRL1. A write takes effect on the next clock and reads back unchanged, with control registers keeping bits 20:0.
- R3: Control fields are shift [4:0], window low bit [9:5], window high bit [14:10], signed [15], cross input [16], cross result [17], raw [18] and force [20:19]. The lane value is the accumulator logically shifted right by the shift amount, then ANDed with a mask whose bits from the low bit to the high bit, both inclusive, are set.
- R4: When the high bit is below the low bit, the mask is all zero.
- R5: With signed set, the windowed value is sign-extended from the window's high bit before it is added. Peek and pop reads return the extended sum.
- R6: Cross input makes a lane use the other lane's accumulator. This applies in raw mode too.
- R7: In raw mode the lane result is the selected accumulator plus the lane's base. FULL still uses the windowed value.
- R8: Address 10 (peek) and 14 (pop) return FULL, which is BASE2 plus both lanes' windowed values, each lane using its own signed setting.
- R9: Force is ORed into bits 29:28 of lane results read on the bus at addresses 8, 9, 12 and 13. It does not change the value written back by a pop, and it does not change FULL.
- R10: A peek read (addresses 8, 9 and 10) leaves both accumulators unchanged.
- R11: A pop read (addresses 12, 13 and 14) returns the same value as the matching peek. At the next clock it loads each accumulator with its own lane's result.
- R12: With cross result set, a pop loads that lane's accumulator with the other lane's result instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a pop address commits on the clock edge |
| rdata | output | 32 | Read data, combinational |

## Verification
The bench targets an inverted window. A design that builds the mask as a wrapped range would pass stray bits there instead of zero. It pairs cross input with raw mode, where a mux placed after the bypass would add the lane's own accumulator. It also pops with force bits set, where a design that wrote back the bus view would corrupt the accumulator's upper bits. Other checks cover sign extension from a narrow window, which a zero-extending design would turn into a large positive term in FULL. They also cover pops with cross result, where updating only the lane read, or ignoring the cross, leaves the wrong accumulator values behind.

// File: rtl/interp_lanes.sv
module interp_lanes #(
  parameter int DW = 32,
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata
);
  localparam int SW = $clog2(DW);

  logic [DW-1:0] acc0, acc1, base0, base1, base2;
  logic [CW-1:0] ctrl0, ctrl1;
  logic [DW-1:0] win0, win1, res0, res1, full;
  logic          pop;

  function automatic logic [DW-1:0] window(input logic [DW-1:0] src, input logic [CW-1:0] c);
    logic [SW-1:0] sh, lo, hi;
    logic [DW-1:0] mask, m;
    sh = c[4:0];
    lo = c[9:5];
    hi = c[14:10];
    mask = (hi >= lo) ? (({DW{1'b1}} << lo) & ({DW{1'b1}} >> (SW'(DW-1) - hi))) : '0;
    m = (src >> sh) & mask;
    if (c[15] && hi >= lo && m[hi]) m = m | ({DW{1'b1}} << hi);
    return m;
  endfunction

  wire [DW-1:0] src0 = ctrl0[16] ? acc1 : acc0;
  wire [DW-1:0] src1 = ctrl1[16] ? acc0 : acc1;

  assign win0 = window(src0, ctrl0);
  assign win1 = window(src1, ctrl1);
  assign res0 = base0 + (ctrl0[18] ? src0 : win0);
  assign res1 = base1 + (ctrl1[18] ? src1 : win1);
  assign full = base2 + win0 + win1;
  assign pop  = rd_en && addr[3:2] == 2'b11 && addr[1:0] != 2'b11;

  wire [DW-1:0] bus0 = res0 | (DW'(ctrl0[20:19]) << 28);
  wire [DW-1:0] bus1 = res1 | (DW'(ctrl1[20:19]) << 28);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        4'd0:         rdata = acc0;
        4'd1:         rdata = acc1;
        4'd2:         rdata = base0;
        4'd3:         rdata = base1;
        4'd4:         rdata = base2;
        4'd5:         rdata = DW'(ctrl0);
        4'd6:         rdata = DW'(ctrl1);
        4'd8, 4'd12:  rdata = bus0;
        4'd9, 4'd13:  rdata = bus1;
        4'd10, 4'd14: rdata = full;
        default:      rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc0 <= '0; acc1 <= '0;
      base0 <= '0; base1 <= '0; base2 <= '0;
      ctrl0 <= '0; ctrl1 <= '0;
    end else begin
      if (pop) begin
        acc0 <= ctrl0[17] ? res1 : res0;
        acc1 <= ctrl1[17] ? res0 : res1;
      end
      if (wr_en) begin
        case (addr)
          4'd0: acc0 <= wdata;
          4'd1: acc1 <= wdata;
          4'd2: base0 <= wdata;
          4'd3: base1 <= wdata;
          4'd4: base2 <= wdata;
          4'd5: ctrl0 <= wdata[CW-1:0];
          4'd6: ctrl1 <= wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

module interp_lanes_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [31:0] acc0,
  input logic [31:0] acc1,
  input logic [31:0] base0,
  input logic [20:0] ctrl0
);
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 32'h0);

  a_r2_acc_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 4'd0 |=> acc0 == $past(wdata));

  a_r4_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 4'd8 && ctrl0[14:10] < ctrl0[9:5] && !ctrl0[18]
    |-> rdata == (base0 | ({30'h0, ctrl0[20:19]} << 28)));

  a_r9_force_visible: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 4'd8 |-> (rdata[29:28] & ctrl0[20:19]) == ctrl0[20:19]);

  a_r10_peek_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr >= 4'd8 && addr <= 4'd10 |=> $stable(acc0) && $stable(acc1));

  a_r11_pop_own: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr == 4'd12 && !ctrl0[17] && ctrl0[20:19] == 2'b00
    |=> acc0 == $past(rdata));
endmodule

bind interp_lanes interp_lanes_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .acc0(acc0), .acc1(acc1), .base0(base0),
  .ctrl0(ctrl0)
);

// File: tb/interp_lanes_bench.sv
module interp_lanes_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic        rd_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails = 0;

  interp_lanes u_interp_lanes (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] cfg(int sh, int lo, int hi, bit sg, bit ci, bit cr, bit raw, int frc);
    return {11'h0, 2'(frc), raw, cr, ci, sg, 5'(hi), 5'(lo), 5'(sh)};
  endfunction

  typedef struct packed {
    logic [31:0] a0, a1, b0, b1, b2, c0, c1, e0, e1, ef;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h1234, 32'hF0, 32'h100, 32'h200, 32'h1000,
      {11'h0, 2'd0, 4'b0000, 5'd7, 5'd0, 5'd4}, {11'h0, 2'd0, 4'b0000, 5'd7, 5'd4, 5'd0},
      32'h123, 32'h2F0, 32'h1113},
    '{32'hF0, 32'h70, 32'h10, 32'h0, 32'h100,
      {11'h0, 2'd0, 4'b0001, 5'd3, 5'd0, 5'd4}, {11'h0, 2'd0, 4'b0001, 5'd3, 5'd0, 5'd4},
      32'hF, 32'h7, 32'h106},
    '{32'hFFFF_FFFF, 32'h3, 32'h55, 32'h2, 32'h0,
      {11'h0, 2'd0, 4'b0001, 5'd2, 5'd8, 5'd0}, {11'h0, 2'd0, 4'b1010, 5'd3, 5'd0, 5'd8},
      32'h55, 32'h1, 32'hF},
    '{32'h40, 32'h99, 32'h0, 32'h1000, 32'h2,
      {11'h0, 2'd3, 4'b0000, 5'd31, 5'd0, 5'd0}, {11'h0, 2'd0, 4'b0010, 5'd7, 5'd0, 5'd4},
      32'h3000_0040, 32'h1004, 32'h46}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 v = rdata;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic load(vec_t v);
    wr(4'd0, v.a0); wr(4'd1, v.a1);
    wr(4'd2, v.b0); wr(4'd3, v.b1); wr(4'd4, v.b2);
    wr(4'd5, v.c0); wr(4'd6, v.c1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state and idle read data
    for (int a = 0; a < 7; a++) begin
      rd(4'(a), v); check("R1 reset reg", v, 32'h0);
    end
    @(negedge clk); addr = 4'd8; #1 check("R1 idle rdata", rdata, 32'h0);

    // R2 write and readback, control masked to 21 bits
    wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, v); check("R2 ctrl readback", v, 32'h001F_FFFF);
    wr(4'd3, 32'hDEAD_BEEF); rd(4'd3, v); check("R2 base readback", v, 32'hDEAD_BEEF);

    // Vector table: R3 R4 R5 R6 R7 R8 R9
    foreach (VECS[i]) begin
      load(VECS[i]);
      rd(4'd8, v);  check("R3/R4/R5/R9 peek lane0", v, VECS[i].e0);
      rd(4'd9, v);  check("R3/R5/R6/R7 peek lane1", v, VECS[i].e1);
      rd(4'd10, v); check("R8 peek full", v, VECS[i].ef);
    end

    // R10 peek leaves accumulators alone
    load(VECS[0]);
    rd(4'd8, v); rd(4'd10, v);
    rd(4'd0, v); check("R10 acc0 after peek", v, 32'h1234);
    rd(4'd1, v); check("R10 acc1 after peek", v, 32'hF0);

    // R11 pop updates both accumulators
    rd(4'd12, v); check("R11 pop value", v, 32'h123);
    rd(4'd0, v);  check("R11 acc0 after pop", v, 32'h123);
    rd(4'd1, v);  check("R11 acc1 after pop", v, 32'h2F0);

    // R12 cross result on lane0, pop via full
    load(VECS[0]);
    wr(4'd5, VECS[0].c0 | (32'h1 << 17));
    rd(4'd14, v); check("R12 pop full value", v, 32'h1113);
    rd(4'd0, v);  check("R12 acc0 crossed", v, 32'h2F0);
    rd(4'd1, v);  check("R12 acc1 own", v, 32'h2F0);

    // R9 forced bits do not feed back
    load(VECS[3]);
    rd(4'd12, v); check("R9 pop bus view", v, 32'h3000_0040);
    rd(4'd0, v);  check("R9 acc0 no force", v, 32'h40);
    rd(4'd1, v);  check("R9 acc1 after pop", v, 32'h1004);

    finish_run();
  end
endmodule